// File: doc/BRIEF.md
# ISA Bus Window Decoder

This block sits between the ISA system bus and a network controller. A pair of board jumpers picks one of four base pairs, each pair holding the base of a 32-byte I/O register window and the base of a 16 KB boot PROM memory window. Both windows move together.

On every bus cycle the block compares the incoming system address against the selected windows. An I/O hit is reported together with the register offset inside the window, so the register file behind it can decode its own slot. A memory read that falls in the PROM window pulls the active-low PROM chip select. In that case the byte-wide PROM data bus is steered onto the low byte of the system data bus with a drive enable that the pad ring uses to leave the bus floating otherwise.

The jumper code is taken while reset is held and frozen afterwards. A board that leaves the jumper pins open reads both as 1 through the pad pull-ups, which selects the last base pair. The decode itself is purely combinational once the block is out of reset, with the outputs held inactive until the first clock edge after reset release.

Top module: `isa_win_decode`

## Requirements
- R1: The jumper code selects the I/O base: 0 gives 0x300, 1 gives 0x320, 2 gives 0x340, 3 gives 0x360.
- R2: The I/O window spans 32 bytes: `io_hit_o` is 1 when address bits 9:5 equal the selected base's bits 9:5. Address bit 0 and bits 19:10 have no effect on the hit.
- R3: While `io_hit_o` is 1, `io_reg_o` equals address bits 4:1. Otherwise it is 0.
- R4: While `aen_i` is 1, `io_hit_o` stays 0 whatever the address.
- R5: The jumper code selects the PROM base: 0 gives 0xC8000, 1 gives 0xCC000, 2 gives 0xD0000, 3 gives 0xD4000. The window spans 16 KB, which is a compare on address bits 19:14.
- R6: `prom_cs_n_o` is 0 only when the address is in the PROM window, `smemr_n_i` is 0 and `refresh_n_i` is 1.
- R7: `sd_lo_oe_o` is 1 exactly while `prom_cs_n_o` is 0. Then `sd_lo_o` equals `prom_data_i`. Otherwise `sd_lo_o` is 0.
- R8: The jumper code is sampled on every clock edge while `rst_n` is 0. After that, jumper changes have no effect until the next reset.
- R9: While `rst_n` is 0, and until the first clock edge after it rises, `io_hit_o` is 0, `prom_cs_n_o` is 1 and `sd_lo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for jumper capture and the ready flag |
| rst_n | input | 1 | Active-low synchronous-capture reset |
| jumper_i | input | 2 | Jumper code selecting the base pair |
| sa_i | input | 20 | System address |
| aen_i | input | 1 | Address enable, 1 during DMA cycles |
| smemr_n_i | input | 1 | Memory read strobe, active low |
| refresh_n_i | input | 1 | Refresh cycle flag, active low |
| prom_data_i | input | 8 | Byte from the boot PROM data bus |
| io_hit_o | output | 1 | Address is in the I/O window |
| io_reg_o | output | 4 | Register offset inside the I/O window |
| prom_cs_n_o | output | 1 | Boot PROM chip select, active low |
| sd_lo_o | output | 8 | Data for system data bits 7:0 |
| sd_lo_oe_o | output | 1 | Drive enable for system data bits 7:0 |

## Verification
Each of the four jumper codes is tried with addresses at the first and last byte of its I/O and PROM windows and at the bytes just outside them, which separates a correct bit-range compare from one that is a bit too wide or too narrow. Addresses with high bits set and bit 0 set show that the ignored address bits really are ignored. An address inside both windows at once shows the two decodes work independently. Memory reads with refresh active, or with no read strobe, show the PROM select qualification. Directed runs change the jumpers after reset and check the outputs while reset is held.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

    // Decoder phase: capture jumpers while in reset, decode afterwards
    typedef enum logic {
        PH_CAPTURE = 1'b0,
        PH_DECODE  = 1'b1
    } win_phase_e;

    // Base field for a given code: windows are adjacent, so base = first + code
    function automatic logic [5:0] field_for_code(input logic [5:0] first,
                                                  input logic [1:0] code);
        return first + {4'd0, code};
    endfunction

endpackage

// File: rtl/isa_win_jumper.sv
module isa_win_jumper
    import isa_win_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] jumper_i,
    output logic [CODE_W-1:0] code_o,
    output logic              live_o
);

    logic [CODE_W-1:0] code_q;
    win_phase_e        phase_q;

    // Jumpers followed each clock while reset is low, frozen after
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= jumper_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_CAPTURE;
        end else begin
            unique case (phase_q)
                PH_CAPTURE: phase_q <= PH_DECODE;
                PH_DECODE:  phase_q <= PH_DECODE;
                default:    phase_q <= PH_CAPTURE;
            endcase
        end
    end

    always_comb begin
        code_o = code_q;
        live_o = (phase_q == PH_DECODE);
    end

endmodule

// File: rtl/isa_win_match.sv
module isa_win_match #(
    parameter int               FIELD_W = 5,
    parameter int               CODE_W  = 2,
    parameter logic [FIELD_W-1:0] FIRST = '0
) (
    input  logic [CODE_W-1:0]  code_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               hit_o
);

    logic [FIELD_W-1:0] base_field;

    always_comb begin
        base_field = FIRST + {{(FIELD_W-CODE_W){1'b0}}, code_i};
        hit_o      = (field_i == base_field);
    end

endmodule

// File: rtl/isa_win_steer.sv
module isa_win_steer #(
    parameter int DATA_W = 8
) (
    input  logic              cs_n_i,
    input  logic [DATA_W-1:0] prom_data_i,
    output logic [DATA_W-1:0] sd_o,
    output logic              oe_o
);

    always_comb begin
        oe_o = ~cs_n_i;
        sd_o = oe_o ? prom_data_i : '0;
    end

endmodule

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
    parameter int          ADDR_W    = 20,
    parameter int          CODE_W    = 2,
    parameter int          DATA_W    = 8,
    parameter int          IO_DEC_W  = 10,
    parameter int          IO_SPAN   = 32,
    parameter int          PROM_SPAN = 16384,
    parameter logic [19:0] IO_FIRST  = 20'h00300,
    parameter logic [19:0] MEM_FIRST = 20'hC8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] jumper_i,
    input  logic [ADDR_W-1:0] sa_i,
    input  logic              aen_i,
    input  logic              smemr_n_i,
    input  logic              refresh_n_i,
    input  logic [DATA_W-1:0] prom_data_i,
    output logic              io_hit_o,
    output logic [3:0]        io_reg_o,
    output logic              prom_cs_n_o,
    output logic [DATA_W-1:0] sd_lo_o,
    output logic              sd_lo_oe_o
);

    localparam int IO_LO   = $clog2(IO_SPAN);
    localparam int IO_HI   = IO_DEC_W - 1;
    localparam int IO_FW   = IO_HI - IO_LO + 1;
    localparam int MEM_LO  = $clog2(PROM_SPAN);
    localparam int MEM_HI  = ADDR_W - 1;
    localparam int MEM_FW  = MEM_HI - MEM_LO + 1;
    localparam logic [IO_FW-1:0]  IO_FIELD0  = IO_FIRST[IO_HI:IO_LO];
    localparam logic [MEM_FW-1:0] MEM_FIELD0 = MEM_FIRST[MEM_HI:MEM_LO];

    logic [CODE_W-1:0] code;
    logic              live;
    logic              io_match;
    logic              mem_match;
    logic              cs_n;
    logic              unused_addr;

    isa_win_jumper #(.CODE_W(CODE_W)) u_jumper (
        .clk      (clk),
        .rst_n    (rst_n),
        .jumper_i (jumper_i),
        .code_o   (code),
        .live_o   (live)
    );

    isa_win_match #(.FIELD_W(IO_FW), .CODE_W(CODE_W), .FIRST(IO_FIELD0)) u_io_match (
        .code_i  (code),
        .field_i (sa_i[IO_HI:IO_LO]),
        .hit_o   (io_match)
    );

    isa_win_match #(.FIELD_W(MEM_FW), .CODE_W(CODE_W), .FIRST(MEM_FIELD0)) u_mem_match (
        .code_i  (code),
        .field_i (sa_i[MEM_HI:MEM_LO]),
        .hit_o   (mem_match)
    );

    always_comb begin
        io_hit_o = live && io_match && !aen_i;
        io_reg_o = io_hit_o ? sa_i[IO_LO-1:1] : '0;
        cs_n     = !(live && mem_match && !smemr_n_i && refresh_n_i);
    end

    assign prom_cs_n_o = cs_n;

    isa_win_steer #(.DATA_W(DATA_W)) u_steer (
        .cs_n_i      (cs_n),
        .prom_data_i (prom_data_i),
        .sd_o        (sd_lo_o),
        .oe_o        (sd_lo_oe_o)
    );

    assign unused_addr = ^{sa_i[0], sa_i[MEM_LO-1:IO_DEC_W]};

endmodule

// File: rtl/isa_win_decode_chk.sv
module isa_win_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  code,
    input logic [19:0] sa_i,
    input logic        aen_i,
    input logic        smemr_n_i,
    input logic        refresh_n_i,
    input logic [7:0]  prom_data_i,
    input logic        io_hit_o,
    input logic [3:0]  io_reg_o,
    input logic        prom_cs_n_o,
    input logic [7:0]  sd_lo_o,
    input logic        sd_lo_oe_o
);

    assert_no_dma_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        aen_i |-> !io_hit_o);

    assert_reg_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit_o |-> (io_reg_o == sa_i[4:1]));

    assert_reg_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit_o |-> (io_reg_o == 4'd0));

    assert_cs_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !prom_cs_n_o |-> (!smemr_n_i && refresh_n_i));

    assert_cs_drives_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !prom_cs_n_o |-> sd_lo_oe_o);

    assert_bus_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_lo_oe_o |-> (sd_lo_o == prom_data_i && !prom_cs_n_o));

    assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(code));

endmodule

bind isa_win_decode isa_win_decode_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .code        (code),
    .sa_i        (sa_i),
    .aen_i       (aen_i),
    .smemr_n_i   (smemr_n_i),
    .refresh_n_i (refresh_n_i),
    .prom_data_i (prom_data_i),
    .io_hit_o    (io_hit_o),
    .io_reg_o    (io_reg_o),
    .prom_cs_n_o (prom_cs_n_o),
    .sd_lo_o     (sd_lo_o),
    .sd_lo_oe_o  (sd_lo_oe_o)
);

// File: tb/isa_win_decode_test.sv
module isa_win_decode_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  jumper_i = 2'd0;
    logic [19:0] sa_i = '0;
    logic        aen_i = 1'b0;
    logic        smemr_n_i = 1'b1;
    logic        refresh_n_i = 1'b1;
    logic [7:0]  prom_data_i = '0;
    logic        io_hit_o;
    logic [3:0]  io_reg_o;
    logic        prom_cs_n_o;
    logic [7:0]  sd_lo_o;
    logic        sd_lo_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    isa_win_decode uut (
        .clk(clk), .rst_n(rst_n), .jumper_i(jumper_i), .sa_i(sa_i),
        .aen_i(aen_i), .smemr_n_i(smemr_n_i), .refresh_n_i(refresh_n_i),
        .prom_data_i(prom_data_i), .io_hit_o(io_hit_o), .io_reg_o(io_reg_o),
        .prom_cs_n_o(prom_cs_n_o), .sd_lo_o(sd_lo_o), .sd_lo_oe_o(sd_lo_oe_o)
    );

    // {code, addr, aen, smemr_n, refresh_n, exp_hit, exp_cs_n}
    localparam int NV = 35;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 20'h00300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd0, 20'h0031F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd0, 20'h002FF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd0, 20'h00320, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd0, 20'h00300, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd0, 20'h0F301, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd0, 20'hC8000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 20'hCBFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd0, 20'hC7FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd0, 20'hCC000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd1, 20'h00320, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd1, 20'h0033F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd1, 20'h0031F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd1, 20'h00340, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd1, 20'hCC000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd1, 20'hCFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd1, 20'hCBFFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd1, 20'hD0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd2, 20'h00340, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd2, 20'h0035F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd2, 20'h00360, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd2, 20'hD0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 20'hD3FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 20'hD4000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd3, 20'h00360, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd3, 20'h0037F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd3, 20'h00380, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd3, 20'h0035F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd3, 20'hD4000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd3, 20'hD7FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd3, 20'hD8000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd3, 20'hD3FFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd3, 20'hD4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd3, 20'hD4000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd3, 20'hD4360, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        jumper_i = code;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic apply(input logic [19:0] a, input logic aen, input logic rd_n,
                         input logic ref_n, input logic [7:0] d);
        @(negedge clk);
        sa_i = a;
        aen_i = aen;
        smemr_n_i = rd_n;
        refresh_n_i = ref_n;
        prom_data_i = d;
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur;
        cur = 2'd0;

        // R9: outputs inactive while reset held, even on matching cycles
        rst_n = 1'b0;
        jumper_i = 2'd3;
        repeat (2) @(posedge clk);
        apply(20'hD4360, 1'b0, 1'b0, 1'b1, 8'h3C);
        check("R9", "io_hit in reset", {19'd0, io_hit_o}, 20'd0);
        check("R9", "cs_n in reset", {19'd0, prom_cs_n_o}, 20'd1);
        check("R9", "oe in reset", {19'd0, sd_lo_oe_o}, 20'd0);

        // Vector walk: R1 R2 R3 R4 R5 R6 R7
        do_reset(VEC[0][26:25]);
        cur = VEC[0][26:25];
        for (int i = 0; i < NV; i++) begin
            logic [7:0] d;
            logic [19:0] a;
            if (VEC[i][26:25] != cur) begin
                cur = VEC[i][26:25];
                do_reset(cur);
            end
            d = 8'h5A + 8'(i);
            a = VEC[i][24:5];
            apply(a, VEC[i][4], VEC[i][3], VEC[i][2], d);
            check("R1/R2/R4", "io_hit", {19'd0, io_hit_o}, {19'd0, VEC[i][1]});
            check("R3", "io_reg", {16'd0, io_reg_o},
                  VEC[i][1] ? {16'd0, a[4:1]} : 20'd0);
            check("R5/R6", "prom_cs_n", {19'd0, prom_cs_n_o}, {19'd0, VEC[i][0]});
            check("R7", "sd_lo_oe", {19'd0, sd_lo_oe_o}, {19'd0, ~VEC[i][0]});
            check("R7", "sd_lo", {12'd0, sd_lo_o}, VEC[i][0] ? 20'd0 : {12'd0, d});
        end

        // R8: jumper change after reset has no effect
        do_reset(2'd0);
        @(negedge clk);
        jumper_i = 2'd3;
        repeat (2) @(posedge clk);
        apply(20'h00360, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R8", "io_hit new code", {19'd0, io_hit_o}, 20'd0);
        apply(20'h00300, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R8", "io_hit held code", {19'd0, io_hit_o}, 20'd1);
        apply(20'hD4000, 1'b0, 1'b0, 1'b1, 8'h77);
        check("R8", "cs_n new code", {19'd0, prom_cs_n_o}, 20'd1);

        // R8: a fresh reset takes the new jumper code
        do_reset(2'd2);
        apply(20'h00340, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R8", "io_hit after re-reset", {19'd0, io_hit_o}, 20'd1);

        // R9: reset reasserted mid-run clears the hit
        @(negedge clk);
        rst_n = 1'b0;
        apply(20'h00340, 1'b0, 1'b1, 1'b1, 8'h00);
        check("R9", "io_hit on reassert", {19'd0, io_hit_o}, 20'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9", "io_hit before first edge", {19'd0, io_hit_o}, 20'd0);
        @(posedge clk);
        #1;
        check("R9", "io_hit after first edge", {19'd0, io_hit_o}, 20'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule